// File: doc/BRIEF.md
# Read-Priority Address-Group Reorderer

This block takes one rank's batch of pending memory requests, each a read or a write with an address and a tag, and sends them back out in a new order. Reads are moved as far forward as the rules allow, but the ordering between requests to the same address is kept. Every read takes along all the earlier writes to its own address that no previous read has already claimed. Each such bundle is an address group. Groups that end in a read leave in the order the reads arrived. Groups made only of writes leave after that, ordered by their oldest write.

Requests are loaded one per handshake into a small batch store. A batch ends on a beat marked last, on a separate close strobe, or by itself when the store is full. The reordered batch then streams out one request per accepted output beat. During streaming no input is taken. A done pulse marks the final output handshake, and the block is then ready to load the next batch.

Top module: `rdpri_reorder`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and done is 0.
- R2: In the load phase in_ready is 1, and a request is stored on each cycle with in_valid and in_ready both high. A batch holds at most 8 requests. The 8th stored request closes the batch even when in_last is 0, and in_ready is 0 from the next cycle on.
- R3: out_valid rises in the cycle after the clock edge that closes the batch. It stays high until the last request leaves. in_ready is 0 the whole time, and one request leaves per cycle with out_valid and out_ready both high.
- R4: Writes to an address that arrive before a read to that address, and after any earlier read to it, leave directly before that read, in their arrival order.
- R5: An address group holds at most one read. A second read to the same address starts a new group, which leaves after the group of the first read.
- R6: Groups that hold a read leave in the arrival order of their reads.
- R7: A write with no later read to its address in the batch belongs to a write-only group. Write-only groups leave after every read-bearing group, ordered by the arrival of each group's oldest write, with arrival order inside a group.
- R8: While out_valid is 1 and out_ready is 0, out_is_read, out_addr and out_tag hold their values into the next cycle.
- R9: done is 1 only in the cycle of the handshake that sends the batch's final request. In the following cycle in_ready is 1 and out_valid is 0.
- R10: A close_set pulse during loading with no in_valid closes the batch at the requests stored so far. If none are stored, the pulse has no effect: out_valid and done stay 0 and in_ready stays 1.
- R11: Each stored request leaves exactly once, with its read flag (1 = read), address and tag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request beat offered |
| in_ready | output | 1 | Batch store accepts a beat (load phase) |
| in_is_read | input | 1 | 1 = read, 0 = write |
| in_addr | input | AW (16) | Target address of the request |
| in_tag | input | TW (8) | Caller's identifier, returned unchanged |
| in_last | input | 1 | This beat closes the batch |
| close_set | input | 1 | Close the batch without a beat |
| out_valid | output | 1 | Reordered request present |
| out_ready | input | 1 | Downstream takes the request |
| out_is_read | output | 1 | Read flag of the outgoing request |
| out_addr | output | AW (16) | Address of the outgoing request |
| out_tag | output | TW (8) | Tag of the outgoing request |
| done | output | 1 | Final request of the batch handshaken |

## Verification
A mixed batch with three addresses, one of them never read, checks that writes come out with their read and that the unread address goes to the end. A batch with reads and writes interleaved to several addresses checks that a second read splits a group and that read-bearing groups follow read age rather than group age. A full all-write batch with no last flag exercises the self-close and the oldest-write ordering between write-only groups. A close-strobe batch of reads drained under alternating back-pressure, together with a write placed after a read, an empty close and a single-entry batch, separates stall handling, post-read writes and the done timing.

// File: rtl/rdpri_pkg.sv
package rdpri_pkg;

  // Phase of the reorderer: collecting a batch, or streaming it out.
  typedef enum logic [0:0] {
    PH_LOAD = 1'b0,
    PH_EMIT = 1'b1
  } phase_t;

endpackage

// File: rtl/rdpri_entry_store.sv
// Batch storage: one slot per request, written in arrival order.
module rdpri_entry_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int TW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_is_read,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_tag,
  output logic          slot_rd   [DEPTH],
  output logic [AW-1:0] slot_addr [DEPTH],
  output logic [TW-1:0] slot_tag  [DEPTH]
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_rd[s]   <= 1'b0;
        slot_addr[s] <= '0;
        slot_tag[s]  <= '0;
      end else if (wr_en && (wr_idx == IW'(s))) begin
        slot_rd[s]   <= wr_is_read;
        slot_addr[s] <= wr_addr;
        slot_tag[s]  <= wr_tag;
      end
    end
  end

endmodule

// File: rtl/rdpri_group_key.sv
// Per-slot sort key: {write_only, anchor, arrival}.
// anchor = arrival of the first read at or after the slot to its address,
// or, for a write-only group, arrival of that group's oldest write.
module rdpri_group_key #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int KW   = 1 + 2 * IW
) (
  input  logic          slot_vld  [DEPTH],
  input  logic          slot_rd   [DEPTH],
  input  logic [AW-1:0] slot_addr [DEPTH],
  output logic [KW-1:0] slot_key  [DEPTH]
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_key
    logic          rd_found;
    logic [IW-1:0] rd_anchor;
    logic          wr_open;
    logic [IW-1:0] wr_oldest;

    // Closest read to the same address at or after this slot.
    always_comb begin
      rd_found  = 1'b0;
      rd_anchor = '0;
      for (int j = DEPTH - 1; j >= 0; j--) begin
        if ((j >= i) && slot_vld[j] && slot_rd[j] &&
            (slot_addr[j] == slot_addr[i])) begin
          rd_found  = 1'b1;
          rd_anchor = IW'(j);
        end
      end
    end

    // Oldest write of the run that this slot belongs to: a read to the
    // same address ends a run, the next write opens a fresh one.
    always_comb begin
      wr_open   = 1'b0;
      wr_oldest = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if ((j <= i) && slot_vld[j] && (slot_addr[j] == slot_addr[i])) begin
          if (slot_rd[j]) begin
            wr_open = 1'b0;
          end else if (!wr_open) begin
            wr_open   = 1'b1;
            wr_oldest = IW'(j);
          end
        end
      end
    end

    assign slot_key[i] = {~rd_found, (rd_found ? rd_anchor : wr_oldest), IW'(i)};
  end

endmodule

// File: rtl/rdpri_rank_sort.sv
// Output position of each valid slot: how many valid keys are smaller.
module rdpri_rank_sort #(
  parameter int DEPTH = 8,
  parameter int KW    = 7,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          slot_vld [DEPTH],
  input  logic [KW-1:0] slot_key [DEPTH],
  output logic [IW-1:0] slot_pos [DEPTH]
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_pos
    logic [IW:0] smaller;
    always_comb begin
      smaller = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (slot_vld[j] && (slot_key[j] < slot_key[i])) begin
          smaller = smaller + 1'b1;
        end
      end
    end
    assign slot_pos[i] = smaller[IW-1:0];
  end

endmodule

// File: rtl/rdpri_seq_ctrl.sv
// Phase control, batch count, output index and output selection.
module rdpri_seq_ctrl
  import rdpri_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int TW    = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_last,
  input  logic          close_set,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic          slot_vld  [DEPTH],
  input  logic [IW-1:0] slot_pos  [DEPTH],
  input  logic          slot_rd   [DEPTH],
  input  logic [AW-1:0] slot_addr [DEPTH],
  input  logic [TW-1:0] slot_tag  [DEPTH],
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_is_read,
  output logic [AW-1:0] out_addr,
  output logic [TW-1:0] out_tag,
  output logic          done
);

  phase_t        phase;
  logic [CW-1:0] fill;
  logic [IW-1:0] oidx;
  logic          accept;
  logic          closing;
  logic          fire;
  logic          final_beat;
  logic [DEPTH-1:0] sel;
  logic [IW-1:0] sel_idx;

  assign in_ready = (phase == PH_LOAD);
  assign accept   = in_valid && in_ready;
  assign wr_en    = accept;
  assign wr_idx   = fill[IW-1:0];

  // A batch ends on a last beat, on a full store, or on a bare close strobe
  // once at least one request is held.
  assign closing = (phase == PH_LOAD) &&
                   ((accept && (in_last || close_set || (fill == CW'(DEPTH - 1)))) ||
                    (!in_valid && close_set && (fill != '0)));

  assign out_valid  = (phase == PH_EMIT);
  assign fire       = out_valid && out_ready;
  assign final_beat = fire && ((CW'(oidx) + CW'(1)) == fill);
  assign done       = final_beat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_vld
    assign slot_vld[i] = (CW'(i) < fill);
    assign sel[i]      = slot_vld[i] && (slot_pos[i] == oidx);
  end

  always_comb begin
    out_is_read = 1'b0;
    out_addr    = '0;
    out_tag     = '0;
    sel_idx     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel[i]) begin
        out_is_read = out_is_read | slot_rd[i];
        out_addr    = out_addr | slot_addr[i];
        out_tag     = out_tag | slot_tag[i];
        sel_idx     = sel_idx | IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LOAD;
      fill  <= '0;
      oidx  <= '0;
    end else begin
      case (phase)
        PH_LOAD: begin
          if (accept) fill <= fill + 1'b1;
          if (closing) begin
            phase <= PH_EMIT;
            oidx  <= '0;
          end
        end
        PH_EMIT: begin
          if (final_beat) begin
            phase <= PH_LOAD;
            fill  <= '0;
          end else if (fire) begin
            oidx <= oidx + 1'b1;
          end
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

  // Arrival index of the previous read sent in this batch (for checks).
  logic          prev_rd_seen;
  logic [IW-1:0] prev_rd_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rd_seen <= 1'b0;
      prev_rd_idx  <= '0;
    end else if (closing) begin
      prev_rd_seen <= 1'b0;
    end else if (fire && out_is_read) begin
      prev_rd_seen <= 1'b1;
      prev_rd_idx  <= sel_idx;
    end
  end

  assert_store_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  assert_emit_follows_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    closing |=> (out_valid && !in_ready));

  assert_read_age_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_is_read && prev_rd_seen) |-> (sel_idx > prev_rd_idx));

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_tag) && $stable(out_addr) && $stable(out_is_read)));

  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (in_ready && !out_valid));

  assert_single_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(sel) == 1));

endmodule

// File: rtl/rdpri_reorder.sv
// Top: batch store, key generation, ranking and sequencing.
module rdpri_reorder #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_is_read,
  input  logic [AW-1:0] in_addr,
  input  logic [TW-1:0] in_tag,
  input  logic          in_last,
  input  logic          close_set,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_is_read,
  output logic [AW-1:0] out_addr,
  output logic [TW-1:0] out_tag,
  output logic          done
);

  localparam int IW = $clog2(DEPTH);
  localparam int KW = 1 + 2 * IW;

  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic          slot_vld  [DEPTH];
  logic          slot_rd   [DEPTH];
  logic [AW-1:0] slot_addr [DEPTH];
  logic [TW-1:0] slot_tag  [DEPTH];
  logic [KW-1:0] slot_key  [DEPTH];
  logic [IW-1:0] slot_pos  [DEPTH];

  rdpri_entry_store #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_is_read (in_is_read),
    .wr_addr    (in_addr),
    .wr_tag     (in_tag),
    .slot_rd    (slot_rd),
    .slot_addr  (slot_addr),
    .slot_tag   (slot_tag)
  );

  rdpri_group_key #(.DEPTH(DEPTH), .AW(AW)) u_key (
    .slot_vld  (slot_vld),
    .slot_rd   (slot_rd),
    .slot_addr (slot_addr),
    .slot_key  (slot_key)
  );

  rdpri_rank_sort #(.DEPTH(DEPTH), .KW(KW)) u_sort (
    .slot_vld (slot_vld),
    .slot_key (slot_key),
    .slot_pos (slot_pos)
  );

  rdpri_seq_ctrl #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_last     (in_last),
    .close_set   (close_set),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .slot_vld    (slot_vld),
    .slot_pos    (slot_pos),
    .slot_rd     (slot_rd),
    .slot_addr   (slot_addr),
    .slot_tag    (slot_tag),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_is_read (out_is_read),
    .out_addr    (out_addr),
    .out_tag     (out_tag),
    .done        (done)
  );

endmodule

// File: tb/rdpri_reorder_bench.sv
module rdpri_reorder_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_is_read, in_last, close_set;
  logic [15:0] in_addr;
  logic [7:0]  in_tag;
  logic        in_ready;
  logic        out_valid, out_ready, out_is_read, done;
  logic [15:0] out_addr;
  logic [7:0]  out_tag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rdpri_reorder u_rdpri_reorder (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_read(in_is_read),
    .in_addr(in_addr), .in_tag(in_tag), .in_last(in_last), .close_set(close_set),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_read(out_is_read),
    .out_addr(out_addr), .out_tag(out_tag), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_beat(input logic rd, input logic [15:0] a,
                           input logic [7:0] t, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_is_read = rd; in_addr = a; in_tag = t; in_last = last;
    #1 check(in_ready == 1'b1, "R2", "in_ready during load", int'(in_ready), 1);
    @(posedge clk);
    #1 in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic expect_start(input string req);
    @(negedge clk);
    #1;
    check(out_valid == 1'b1, req, "out_valid after close", int'(out_valid), 1);
    check(in_ready == 1'b0, "R3", "in_ready while emitting", int'(in_ready), 0);
  endtask

  // Drains n requests, comparing tags; bp=1 applies alternating back-pressure.
  task automatic drain(input string req, input int n, input logic [7:0] exp[8], input bit bp);
    int got = 0;
    int cyc = 0;
    bit stalled = 0;
    logic [7:0] held = '0;
    while (got < n && cyc < 60) begin
      if (cyc > 0) @(negedge clk);
      if (stalled) begin
        #1 check(out_valid && out_tag == held, "R8", "held tag on stall", int'(out_tag), int'(held));
      end
      out_ready = bp ? cyc[0] : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        check(out_tag == exp[got], req, "output order tag", int'(out_tag), int'(exp[got]));
        check(done == (got == n - 1), "R9", "done on final handshake", int'(done), int'(got == n - 1));
        got++;
      end
      stalled = out_valid && !out_ready;
      held    = out_tag;
      cyc++;
      @(posedge clk);
    end
    check(got == n, "R11", "requests emitted", got, n);
    @(negedge clk);
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9", "idle after done",
          int'({out_valid, in_ready}), 1);
    out_ready = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 0; in_is_read = 0; in_addr = '0; in_tag = '0;
    in_last = 0; close_set = 0; out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1 && out_valid == 0 && done == 0, "R1", "reset outputs",
          int'({in_ready, out_valid, done}), 4);
    rst_n = 1'b1;
  endtask

  // Mixed batch: writes join their read; unread address goes last (R4, R7).
  task automatic t_example;
    load_beat(0, 16'h1, 8'd1, 0);
    load_beat(0, 16'h2, 8'd4, 0);
    load_beat(0, 16'h3, 8'd6, 0);
    load_beat(0, 16'h2, 8'd7, 0);
    load_beat(1, 16'h2, 8'd8, 0);
    load_beat(1, 16'h3, 8'd9, 1);
    expect_start("R3");
    drain("R4", 6, '{8'd4, 8'd7, 8'd8, 8'd6, 8'd9, 8'd1, 8'd0, 8'd0}, 0);
  endtask

  // Two reads to one address split groups; read age sets order (R5, R6, R7).
  task automatic t_split_groups;
    load_beat(0, 16'h5, 8'd10, 0);
    load_beat(1, 16'h7, 8'd11, 0);
    load_beat(0, 16'h9, 8'd12, 0);
    load_beat(1, 16'h5, 8'd13, 0);
    load_beat(0, 16'h5, 8'd14, 0);
    load_beat(1, 16'h5, 8'd15, 0);
    load_beat(0, 16'h9, 8'd16, 1);
    expect_start("R3");
    drain("R5", 7, '{8'd11, 8'd10, 8'd13, 8'd14, 8'd15, 8'd12, 8'd16, 8'd0}, 0);
  endtask

  // Full write-only batch without a last flag closes by itself (R2, R7).
  task automatic t_full_writes;
    load_beat(0, 16'h1, 8'd20, 0);
    load_beat(0, 16'h2, 8'd21, 0);
    load_beat(0, 16'h1, 8'd22, 0);
    load_beat(0, 16'h3, 8'd23, 0);
    load_beat(0, 16'h2, 8'd24, 0);
    load_beat(0, 16'h4, 8'd25, 0);
    load_beat(0, 16'h3, 8'd26, 0);
    load_beat(0, 16'h1, 8'd27, 0);
    expect_start("R2");
    drain("R7", 8, '{8'd20, 8'd22, 8'd27, 8'd21, 8'd24, 8'd23, 8'd26, 8'd25}, 0);
  endtask

  // Reads closed by a bare strobe, drained under back-pressure (R10, R5, R8).
  task automatic t_close_stall;
    load_beat(1, 16'h3, 8'd30, 0);
    load_beat(1, 16'h3, 8'd31, 0);
    load_beat(1, 16'h1, 8'd32, 0);
    @(negedge clk);
    close_set = 1'b1;
    @(posedge clk);
    #1 close_set = 1'b0;
    expect_start("R10");
    drain("R6", 3, '{8'd30, 8'd31, 8'd32, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0}, 1);
  endtask

  // Empty close has no effect; single entry keeps its fields (R10, R11).
  task automatic t_empty_single;
    @(negedge clk);
    close_set = 1'b1;
    @(posedge clk);
    #1 close_set = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid == 0 && done == 0 && in_ready == 1, "R10", "empty close inert",
            int'({out_valid, done, in_ready}), 1);
    end
    load_beat(1, 16'hABCD, 8'd40, 1);
    @(negedge clk);
    #1 check(out_valid && out_is_read && out_addr == 16'hABCD, "R11", "fields carried",
             int'(out_addr), 16'hABCD);
    drain("R9", 1, '{8'd40, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0}, 0);
  endtask

  // Write after the read to its address forms a trailing group (R7).
  task automatic t_write_after_read;
    load_beat(1, 16'h2, 8'd50, 0);
    load_beat(0, 16'h2, 8'd51, 0);
    load_beat(0, 16'h6, 8'd52, 0);
    load_beat(1, 16'h6, 8'd53, 1);
    expect_start("R3");
    drain("R7", 4, '{8'd50, 8'd52, 8'd53, 8'd51, 8'd0, 8'd0, 8'd0, 8'd0}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_example();
    t_split_groups();
    t_full_writes();
    t_close_stall();
    t_empty_single();
    t_write_after_read();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule